// File: doc/BRIEF.md
# Ultra DMA Burst Data Sender

This block is the sending end of an ATA Ultra DMA mode 2 data-out burst. It runs on one synchronous system clock and turns timing limits given in nanoseconds into minimum cycle counts. When words are waiting at its stream input, it raises the burst request. It then waits for the host's active-low acknowledge and for an envelope delay. After that it places words on the 16-bit data bus and toggles the strobe once per word, so that data moves on both strobe edges.

The recipient can pause the burst by dropping its ready line. The sender then stops toggling the strobe, and it also stalls on its own whenever the input stream is empty. When the host raises stop, the sender drops its request and places a CRC-16 of the burst's data words on the bus. It sends that CRC with one last strobe transition and holds it there until the host releases acknowledge. Words are taken from a valid/ready stream: a word is popped in the cycle its strobe edge is issued. The source must keep its head word stable while valid is high and ready is low.

Top module: `udma_burst_tx`

## Requirements
- R1: While reset is held and right after it, `dmarq` is 0, `strobe` is 1, `dd` is 0x0000 and `src_ready` is 0.
- R2: In the idle state, `dmarq` goes high at the first clock edge that sees `src_valid` high. No `strobe` transition ever occurs while `dmack_n` is high.
- R3: When a word is waiting as `dmack_n` falls, the first strobe transition of the burst comes no earlier than 20 ns and no later than 170 ns after that fall.
- R4: `dd` is stable for at least 34 ns before every strobe transition and does not change within 6 ns after one.
- R5: Consecutive strobe transitions are at least 55 ns apart, and transitions two apart (same polarity) are at least 117 ns apart.
- R6: Every data transition of `strobe` (both polarities) carries the next stream word in arrival order. `src_ready` is high for exactly one cycle per data transition and never otherwise.
- R7: No data transition is issued from a cycle in which `dmardy` is low, so at most one transition (zero in this design) follows a negation of `dmardy`.
- R8: After `host_stop` goes high, `dmarq` is low within 150 ns. Exactly one more strobe transition follows, and it carries the CRC-16 (polynomial 0x1021, processed MSB first, seed 0x4ABA) of the burst's data words, which is 0x4ABA if no word was sent.
- R9: After `host_stop` goes high, no word is popped. Words not sent stay in the stream and are sent in the next burst.
- R10: After the CRC transition, `dd` keeps the CRC and `dmarq` stays low until `dmack_n` returns high. After that, `dmarq` rises again only if words are waiting.
- R11: While the stream is empty during a burst, `strobe` does not toggle. The burst resumes when a word arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | 16 | Head word of the outgoing stream |
| src_valid | input | 1 | Stream has a word |
| src_ready | output | 1 | Head word popped this cycle |
| dmarq | output | 1 | Burst request to the host |
| dmack_n | input | 1 | Host burst acknowledge, active low |
| host_stop | input | 1 | Host request to end the burst |
| dmardy | input | 1 | Recipient ready, high to keep words flowing |
| strobe | output | 1 | Data strobe, one transition per word |
| dd | output | 16 | Data bus |

## Verification
The hardest case to reach from the ports is a host stop that lands while a word is already loaded on the bus but not yet strobed, or before any word has been sent. In those cases the block must discard the load without popping it and must send the seed-only CRC. The stimulus mixes directed bursts, which stop after zero, a few or all available words, with seeded random bursts. The random bursts choose stop points, toggle ready at random, trickle words in and vary the acknowledge delay. One directed burst starves the stream after the first word. A nanosecond-based monitor compares every strobe transition with the stream order and with a CRC that the bench computes itself.

// File: rtl/udma_tx_pkg.sv
package udma_tx_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ENV, ST_XFER, ST_CRC, ST_TAIL, ST_RELEASE
  } tx_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int cyc_ceil(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // one 16-bit word into CRC-16 (x^16+x^12+x^5+1), MSB first
  function automatic logic [WORD_W-1:0] crc16_word(logic [WORD_W-1:0] crc,
                                                    logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ w[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

endpackage

// File: rtl/udma_tx_crc.sv
module udma_tx_crc
  import udma_tx_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= SEED;
    else if (clear) crc <= SEED;
    else if (en)    crc <= crc16_word(crc, din);
  end

endmodule

// File: rtl/udma_tx_pacer.sv
module udma_tx_pacer #(
  parameter int GAP_CYC   = 6,
  parameter int HOLD_CYC  = 1,
  parameter int SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic edge_go,
  input  logic load,
  output logic gap_ok,
  output logic hold_ok,
  output logic setup_ok
);

  localparam int GW = $clog2(GAP_CYC + 1) + 1;
  localparam int SW = $clog2(SETUP_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_L   = GW'(GAP_CYC);
  localparam logic [GW-1:0] HOLD_L  = GW'(HOLD_CYC);
  localparam logic [SW-1:0] SETUP_L = SW'(SETUP_CYC);

  logic [GW-1:0] gap_q;    // cycles since the last strobe edge, saturating
  logic [SW-1:0] setup_q;  // cycles the bus word has been stable, 0 = none

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= GAP_L;
      setup_q <= '0;
    end else begin
      if (arm)                gap_q <= GAP_L;
      else if (edge_go)       gap_q <= GW'(1);
      else if (gap_q < GAP_L) gap_q <= gap_q + GW'(1);

      if (arm || edge_go)                           setup_q <= '0;
      else if (load)                                setup_q <= SW'(1);
      else if (setup_q != '0 && setup_q < SETUP_L)  setup_q <= setup_q + SW'(1);
    end
  end

  assign gap_ok   = gap_q >= GAP_L;
  assign hold_ok  = gap_q >= HOLD_L;
  assign setup_ok = setup_q >= SETUP_L;

endmodule

// File: rtl/udma_tx_fsm.sv
module udma_tx_fsm
  import udma_tx_pkg::*;
#(
  parameter int ENV_CYC  = 2,
  parameter int TAIL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              dmack_n,
  input  logic              host_stop,
  input  logic              dmardy,
  input  logic [WORD_W-1:0] crc_val,
  input  logic              gap_ok,
  input  logic              hold_ok,
  input  logic              setup_ok,
  output logic              dmarq,
  output logic              strobe,
  output logic [WORD_W-1:0] dd,
  output logic              word_ready,
  output logic              fire,
  output logic              load,
  output logic              arm,
  output tx_state_e         st
);

  localparam int CW = $clog2(imax(ENV_CYC, TAIL_CYC) + 1) + 1;
  localparam logic [CW-1:0] ENV_LAST  = CW'(ENV_CYC - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          loaded_q;
  logic          data_phase;
  logic          crc_phase;

  assign data_phase = (st == ST_XFER) && !host_stop;
  assign crc_phase  = (st == ST_CRC);
  assign load       = !loaded_q && hold_ok && ((data_phase && word_valid) || crc_phase);
  assign fire       = loaded_q && setup_ok && gap_ok && ((data_phase && dmardy) || crc_phase);
  assign word_ready = fire && data_phase;
  assign arm        = (st == ST_REQ) && !dmack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dmarq    <= 1'b0;
      strobe   <= 1'b1;
      dd       <= '0;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (word_valid) begin
          dmarq <= 1'b1;
          st    <= ST_REQ;
        end
        ST_REQ: if (!dmack_n) begin
          cnt_q <= '0;
          st    <= ST_ENV;
        end
        ST_ENV: begin
          if (cnt_q == ENV_LAST) begin
            loaded_q <= 1'b0;
            st       <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_XFER: begin
          if (host_stop) begin
            dmarq    <= 1'b0;
            loaded_q <= 1'b0;
            st       <= ST_CRC;
          end else begin
            if (load) begin
              dd       <= word_data;
              loaded_q <= 1'b1;
            end
            if (fire) begin
              strobe   <= ~strobe;
              loaded_q <= 1'b0;
            end
          end
        end
        ST_CRC: begin
          if (load) begin
            dd       <= crc_val;
            loaded_q <= 1'b1;
          end
          if (fire) begin
            strobe   <= ~strobe;
            loaded_q <= 1'b0;
            cnt_q    <= '0;
            st       <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (cnt_q == TAIL_LAST) st <= ST_RELEASE;
          else                    cnt_q <= cnt_q + CW'(1);
        end
        ST_RELEASE: if (dmack_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/udma_burst_tx.sv
module udma_burst_tx
  import udma_tx_pkg::*;
#(
  parameter int                CLK_NS    = 10,
  parameter int                T_CYC_NS  = 55,
  parameter int                T_2CYC_NS = 117,
  parameter int                T_DVS_NS  = 34,
  parameter int                T_DVH_NS  = 6,
  parameter int                T_ENV_NS  = 20,
  parameter int                T_ACK_NS  = 20,
  parameter logic [WORD_W-1:0] CRC_SEED  = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              dmarq,
  input  logic              dmack_n,
  input  logic              host_stop,
  input  logic              dmardy,
  output logic              strobe,
  output logic [WORD_W-1:0] dd
);

  localparam int DVS_CYC  = imax(1, cyc_ceil(T_DVS_NS, CLK_NS));
  localparam int DVH_CYC  = imax(1, cyc_ceil(T_DVH_NS, CLK_NS));
  localparam int WORD_CYC = imax(cyc_ceil(T_CYC_NS, CLK_NS),
                                 (cyc_ceil(T_2CYC_NS, CLK_NS) + 1) / 2);
  localparam int GAP_CYC  = imax(WORD_CYC, DVH_CYC + DVS_CYC);
  localparam int ENV_CYC  = imax(1, imax(cyc_ceil(T_ENV_NS, CLK_NS), cyc_ceil(T_ACK_NS, CLK_NS)));
  localparam int TAIL_CYC = imax(1, imax(DVH_CYC, cyc_ceil(T_ACK_NS, CLK_NS)));

  logic      fire, load, arm;
  logic      gap_ok, hold_ok, setup_ok;
  logic [WORD_W-1:0] crc_val;
  tx_state_e st;

  udma_tx_pacer #(.GAP_CYC(GAP_CYC), .HOLD_CYC(DVH_CYC), .SETUP_CYC(DVS_CYC)) pacer_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .edge_go(fire), .load(load),
    .gap_ok(gap_ok), .hold_ok(hold_ok), .setup_ok(setup_ok)
  );

  udma_tx_crc #(.SEED(CRC_SEED)) crc_i (
    .clk(clk), .rst_n(rst_n), .clear(arm), .en(src_ready), .din(dd), .crc(crc_val)
  );

  udma_tx_fsm #(.ENV_CYC(ENV_CYC), .TAIL_CYC(TAIL_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .word_valid(src_valid), .word_data(src_data),
    .dmack_n(dmack_n), .host_stop(host_stop), .dmardy(dmardy), .crc_val(crc_val),
    .gap_ok(gap_ok), .hold_ok(hold_ok), .setup_ok(setup_ok),
    .dmarq(dmarq), .strobe(strobe), .dd(dd), .word_ready(src_ready),
    .fire(fire), .load(load), .arm(arm), .st(st)
  );

  // observation of the pins for the checks below
  localparam int GW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_L = GW'(GAP_CYC);

  logic              strobe_prev;
  logic [WORD_W-1:0] dd_prev;
  logic [GW-1:0]     since_q;
  logic              strobe_edge;

  assign strobe_edge = strobe != strobe_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b1;
      dd_prev     <= '0;
      since_q     <= GAP_L;
    end else begin
      strobe_prev <= strobe;
      dd_prev     <= dd;
      if (strobe_edge)          since_q <= GW'(1);
      else if (since_q < GAP_L) since_q <= since_q + GW'(1);
    end
  end

  // R4
  bus_stable_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge |-> dd == dd_prev);

  // R5
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge |-> since_q >= GAP_L);

  // R2
  no_edge_unacked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge |-> !dmack_n);

  // R9
  pop_in_burst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (src_valid && dmarq && !host_stop));

  // R8
  stop_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && host_stop) |=> !dmarq);

  // R7
  pause_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_edge && $past(st == ST_XFER)) |-> $past(dmardy));

endmodule

// File: tb/udma_burst_tx_tb_top.sv
`timescale 1ns/1ps
module udma_burst_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_data;
  logic        src_valid, src_ready;
  logic        dmarq, dmack_n, host_stop, dmardy, strobe;
  logic [15:0] dd;

  always #5 clk = ~clk;

  logic [15:0] src_mem [0:1023];
  int src_len, src_idx;
  assign src_valid = src_idx < src_len;
  assign src_data  = src_valid ? src_mem[src_idx[9:0]] : 16'h0000;

  udma_burst_tx dut_i (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .dmarq(dmarq), .dmack_n(dmack_n), .host_stop(host_stop),
    .dmardy(dmardy), .strobe(strobe), .dd(dd)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [15:0] w);
    logic [15:0] r;
    r = c ^ w;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // shared monitor state
  logic        rdy_s, dm_s;
  int          edges_burst, pause_edges;
  bit          fs_check, first_pending, crc_seen;
  longint      t_ack, t_stop, dmarq_fall_t, last_edge_t, prev_edge_t, last_dd_t;
  logic [15:0] bcrc, crc_final;

  initial forever begin
    @(negedge clk); #2;
    rdy_s = src_ready;
    dm_s  = dmardy;
  end

  initial begin : monitor
    logic p_strobe, p_dmarq;
    logic [15:0] p_dd;
    longint now;
    p_strobe = 1'b1; p_dmarq = 1'b0; p_dd = 16'h0; last_dd_t = 0;
    forever begin
      @(posedge clk); #1;
      now = $time;
      if (rst_n) begin
        if (dd != p_dd) begin
          if (last_edge_t >= 0) chk(now - last_edge_t >= 6, "R4", "hold after edge ns", now - last_edge_t, 6);
          last_dd_t = now;
        end
        if (p_dmarq && !dmarq) dmarq_fall_t = now;
        if (strobe != p_strobe) begin
          chk(!dmack_n, "R2", "edge while dmack_n high", dmack_n, 0);
          chk(now - last_dd_t >= 34, "R4", "setup before edge ns", now - last_dd_t, 34);
          if (last_edge_t >= 0) chk(now - last_edge_t >= 55, "R5", "edge gap ns", now - last_edge_t, 55);
          if (prev_edge_t >= 0) chk(now - prev_edge_t >= 117, "R5", "two-edge gap ns", now - prev_edge_t, 117);
          if (first_pending && fs_check)
            chk(now - t_ack >= 20 && now - t_ack <= 170, "R3", "first edge ns", now - t_ack, 170);
          first_pending = 0;
          if (host_stop) begin
            chk(dd == bcrc, "R8", "crc word", dd, bcrc);
            chk(!rdy_s, "R9", "pop on crc edge", rdy_s, 0);
            crc_final = bcrc;
            crc_seen  = 1;
          end else begin
            chk(dd == src_mem[src_idx[9:0]], "R6", "data word", dd, src_mem[src_idx[9:0]]);
            chk(rdy_s, "R6", "pop with data edge", rdy_s, 1);
            if (!dm_s) pause_edges++; else pause_edges = 0;
            chk(pause_edges <= 1, "R7", "edges after ready low", pause_edges, 1);
            bcrc = ref_crc(bcrc, dd);
            edges_burst++;
            if (rdy_s) src_idx++;
          end
          prev_edge_t = last_edge_t;
          last_edge_t = now;
        end else if (rdy_s) begin
          chk(0, "R6", "pop without edge", 1, 0);
          src_idx++;
        end
      end
      p_strobe = strobe; p_dd = dd; p_dmarq = dmarq;
    end
  end

  task automatic push_word();
    src_mem[src_len[9:0]] = 16'($urandom);
    src_len++;
  endtask

  task automatic do_burst(input int nw, input int stop_at, input bit rnd_rdy,
                          input bit trickle, input bit starve, input int ack_dly);
    int  pushed = 0;
    int  start_idx;
    bit  was_empty;
    bit  starved = 0;
    logic e0;
    was_empty = (src_idx == src_len) && !dmarq;
    @(negedge clk);
    if (nw > 0) begin
      if (trickle || starve) begin push_word(); pushed = 1; end
      else begin
        for (int i = 0; i < nw; i++) push_word();
        pushed = nw;
      end
    end
    if (was_empty) begin
      @(negedge clk);
      chk(dmarq == 1'b1, "R2", "request after valid", dmarq, 1);
    end
    while (!dmarq) @(negedge clk);
    repeat (ack_dly) @(negedge clk);
    edges_burst = 0; pause_edges = 0; bcrc = 16'h4ABA; crc_seen = 0;
    last_edge_t = -1; prev_edge_t = -1; dmarq_fall_t = -1;
    fs_check = src_idx < src_len; first_pending = 1;
    start_idx = src_idx; t_ack = $time; dmack_n = 1'b0;
    while (edges_burst < stop_at) begin
      @(negedge clk);
      if (rnd_rdy) dmardy = ($urandom % 4) != 0;
      if (trickle && pushed < nw && ($urandom % 4) == 0) begin push_word(); pushed++; end
      if (starve && !starved && edges_burst == 1) begin
        e0 = strobe;
        repeat (20) @(negedge clk);
        // R11: empty stream, no transition
        chk(strobe == e0 && edges_burst == 1, "R11", "edges while empty", edges_burst, 1);
        starved = 1;
        while (pushed < nw) begin push_word(); pushed++; end
      end
    end
    dmardy = 1'b1; host_stop = 1'b1; t_stop = $time;
    while (!crc_seen) @(negedge clk);
    chk(dmarq_fall_t >= t_stop && dmarq_fall_t - t_stop <= 150, "R8", "request drop ns",
        dmarq_fall_t - t_stop, 150);
    chk(src_idx - start_idx == stop_at, "R9", "words popped in burst", src_idx - start_idx, stop_at);
    while (pushed < nw) begin push_word(); pushed++; end
    repeat (3) @(negedge clk);
    chk(dd == crc_final, "R10", "crc held on bus", dd, crc_final);
    chk(dmarq == 1'b0, "R10", "request low before release", dmarq, 0);
    host_stop = 1'b0; dmack_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dmarq == (src_idx < src_len), "R10", "re-request only if words wait", dmarq, src_idx < src_len);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int nw, avail, sa;
    void'($urandom(32'd7331));
    rst_n = 1'b0; dmack_n = 1'b1; host_stop = 1'b0; dmardy = 1'b1;
    src_len = 0; src_idx = 0; crc_final = 16'h0; bcrc = 16'h4ABA;
    last_edge_t = -1; prev_edge_t = -1; first_pending = 0; crc_seen = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(dmarq == 0 && strobe == 1 && dd == 0 && src_ready == 0, "R1", "reset outputs",
        {dmarq, strobe, src_ready}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dmarq == 0 && strobe == 1 && dd == 0, "R1", "outputs after reset", {dmarq, strobe}, 2'b01);
    do_burst(5, 5, 0, 0, 0, 4);   // full burst, late acknowledge
    do_burst(6, 2, 0, 0, 0, 1);   // early stop, four words stay
    do_burst(0, 3, 1, 0, 0, 0);   // leftovers with random pausing
    do_burst(0, 0, 0, 0, 0, 2);   // stop before any word: seed-only CRC
    do_burst(0, 1, 0, 0, 0, 0);   // drain the last leftover
    do_burst(3, 3, 0, 0, 1, 0);   // starved stream mid-burst
    for (int b = 0; b < 30; b++) begin
      nw    = 1 + ($urandom % 12);
      avail = (src_len - src_idx) + nw;
      sa    = $urandom % (avail + 1);
      do_burst(nw, sa, 1'($urandom), 1'($urandom), 0, $urandom % 5);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule